// File: doc/BRIEF.md
# Register remap table builder

The block keeps a small set of sixteen configuration slots. Each slot says how one architectural register, integer or floating point, is to be reinterpreted when an instruction names it: where its run of physical registers starts, which element width to use, whether it is a vector and whether it is packed SIMD. An issue stage reading such a sparse set would need an associative search on every operand. Instead, the block expands the slots into two dense per-register tables, one for the integer class and one for the floating-point class. A lookup then becomes a plain index by class and register number.

Every write to a slot triggers a rebuild. The rebuild spends one cycle wiping both tables. It then spends one cycle on each slot, in ascending slot order, writing that slot's fields into the row picked by its class bit and key register. During the rebuild `busy_o` is high and lookups return the wiped defaults. A later write restarts the rebuild from the wipe.

Top module: `regmap_builder`

## Requirements
- R1: After reset `busy_o` is 0 and every lookup returns the default row. The default row has `lk_start_o` equal to `lk_reg_i`, and `lk_ew_o`, `lk_vec_o`, `lk_simd_o` and `lk_bank_o` all 0.
- R2: A write on `cfg_we_i` sampled at a clock edge makes `busy_o` high from that edge for exactly 17 cycles: one wipe cycle plus one cycle for each of the 16 slots.
- R3: While `busy_o` is high, every lookup returns the default row.
- R4: Once idle, a lookup whose class and register match an applied slot with the vector bit set returns that slot's target register on `lk_start_o`, together with its width code and SIMD bit. The word on `cfg_data_i` is laid out as follows: bit 15 is the class (0 integer, 1 FP), bits 14:10 the key register, bits 9:5 the target register, bits 4:3 the width code (0 default, 1 half of default, 2 eight bits, 3 sixteen bits), bit 2 vector, bit 1 packed SIMD and bit 0 bank.
- R5: When the row is not a vector, `lk_start_o` equals `lk_reg_i`, while the width code and the SIMD bit are still reported.
- R6: A slot affects only the table of its own class. The same key in the other class keeps its default row.
- R7: When several slots share a class and key, the slot with the highest index decides the row.
- R8: The wipe precedes the apply. When a slot is rewritten with a different key, the row of its old key returns to the default.
- R9: A slot whose bank bit is 1 is reserved and is not applied, so its row stays as the other slots leave it, and `lk_bank_o` is always 0.
- R10: A write while `busy_o` is high restarts the rebuild, so `busy_o` stays high for 17 cycles after the last write.
- R11: While idle with no write, the lookup outputs depend only on the current lookup inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_idx_i | input | 4 | Slot index to write |
| cfg_data_i | input | 16 | Slot contents, layout as in R4 |
| busy_o | output | 1 | Rebuild in progress |
| lk_cls_i | input | 1 | Lookup class, 0 integer, 1 FP |
| lk_reg_i | input | 5 | Lookup register number |
| lk_start_o | output | 5 | Remapped start register |
| lk_ew_o | output | 2 | Element width code |
| lk_vec_o | output | 1 | Vector flag |
| lk_simd_o | output | 1 | Packed SIMD flag |
| lk_bank_o | output | 1 | Bank bit, always 0 |

## Verification
The properties assume that `cfg_we_i` is never X after reset and that the lookup inputs are settled by each sampling edge. For its idle-hold check, the checker requires the lookup inputs to stay stable across two edges. The stimulus writes only at falling edges and moves the lookup inputs only between rising edges. It draws keys from a narrow range so that slots collide in the same class and key, and it waits out each rebuild before comparing rows, except where busy-state behaviour is the thing under test.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  parameter int unsigned N_ENT  = 16;
  parameter int unsigned N_REGS = 32;
  parameter int unsigned N_CLS  = 2;
  localparam int unsigned REG_W = $clog2(N_REGS);
  localparam int unsigned IDX_W = $clog2(N_ENT);
  localparam int unsigned EW_W  = 2;

  typedef struct packed {
    logic             cls;
    logic [REG_W-1:0] key;
    logic [REG_W-1:0] tgt;
    logic [EW_W-1:0]  ew;
    logic             vec;
    logic             simd;
    logic             bank;
  } cfg_ent_t;

  typedef struct packed {
    logic [REG_W-1:0] tgt;
    logic [EW_W-1:0]  ew;
    logic             vec;
    logic             simd;
  } row_t;

  localparam int unsigned CFG_W = $bits(cfg_ent_t);
endpackage

// File: rtl/regmap_cfg_store.sv
module regmap_cfg_store
  import regmap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  cfg_ent_t         wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output cfg_ent_t         rd_o
);
  cfg_ent_t slot_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g))      slot_q[g] <= wr_data_i;
    end
  end

  assign rd_o = slot_q[rd_idx_i];
endmodule

// File: rtl/regmap_sequencer.sv
module regmap_sequencer
  import regmap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             clr_o,
  output logic             apply_o,
  output logic [IDX_W-1:0] idx_o
);
  typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_APPLY} state_e;
  state_e           state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= S_CLEAR;  // any write restarts from the wipe
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        S_CLEAR: state_q <= S_APPLY;
        S_APPLY: begin
          if (idx_q == IDX_W'(N_ENT - 1)) state_q <= S_IDLE;
          else                            idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = state_q != S_IDLE;
  assign clr_o   = state_q == S_CLEAR;
  assign apply_o = state_q == S_APPLY;
  assign idx_o   = idx_q;
endmodule

// File: rtl/regmap_tables.sv
module regmap_tables
  import regmap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             apply_i,
  input  cfg_ent_t         ent_i,
  input  logic             rd_cls_i,
  input  logic [REG_W-1:0] rd_reg_i,
  output row_t             rd_o
);
  row_t row_q [N_CLS][N_REGS];

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    // bank 1 is reserved: such slots are skipped
    logic hit;
    assign hit = apply_i && !ent_i.bank && (ent_i.cls == 1'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < N_REGS; r++) row_q[c][r] <= '0;
      end else if (clr_i) begin
        for (int r = 0; r < N_REGS; r++) row_q[c][r] <= '0;
      end else if (hit) begin
        row_q[c][ent_i.key] <= '{tgt: ent_i.tgt, ew: ent_i.ew,
                                 vec: ent_i.vec, simd: ent_i.simd};
      end
    end
  end

  assign rd_o = row_q[rd_cls_i][rd_reg_i];
endmodule

// File: rtl/regmap_lookup.sv
module regmap_lookup
  import regmap_pkg::*;
(
  input  logic             busy_i,
  input  logic [REG_W-1:0] reg_i,
  input  row_t             row_i,
  output logic [REG_W-1:0] start_o,
  output logic [EW_W-1:0]  ew_o,
  output logic             vec_o,
  output logic             simd_o,
  output logic             bank_o
);
  row_t eff;
  assign eff     = busy_i ? row_t'('0) : row_i;
  assign start_o = eff.vec ? eff.tgt : reg_i;
  assign ew_o    = eff.ew;
  assign vec_o   = eff.vec;
  assign simd_o  = eff.simd;
  assign bank_o  = 1'b0;  // only bank 0 is ever applied
endmodule

// File: rtl/regmap_builder.sv
module regmap_builder
  import regmap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic             busy_o,
  input  logic             lk_cls_i,
  input  logic [REG_W-1:0] lk_reg_i,
  output logic [REG_W-1:0] lk_start_o,
  output logic [EW_W-1:0]  lk_ew_o,
  output logic             lk_vec_o,
  output logic             lk_simd_o,
  output logic             lk_bank_o
);
  cfg_ent_t         cur_ent;
  row_t             row;
  logic             clr, apply;
  logic [IDX_W-1:0] seq_idx;

  regmap_cfg_store u_store (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wr_idx_i  (cfg_idx_i),
    .wr_data_i (cfg_ent_t'(cfg_data_i)),
    .rd_idx_i  (seq_idx),
    .rd_o      (cur_ent)
  );

  regmap_sequencer u_seq (
    .clk_i, .rst_ni,
    .start_i (cfg_we_i),
    .busy_o  (busy_o),
    .clr_o   (clr),
    .apply_o (apply),
    .idx_o   (seq_idx)
  );

  regmap_tables u_tbl (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .apply_i  (apply),
    .ent_i    (cur_ent),
    .rd_cls_i (lk_cls_i),
    .rd_reg_i (lk_reg_i),
    .rd_o     (row)
  );

  regmap_lookup u_lk (
    .busy_i  (busy_o),
    .reg_i   (lk_reg_i),
    .row_i   (row),
    .start_o (lk_start_o),
    .ew_o    (lk_ew_o),
    .vec_o   (lk_vec_o),
    .simd_o  (lk_simd_o),
    .bank_o  (lk_bank_o)
  );
endmodule

// File: rtl/regmap_builder_chk.sv
module regmap_builder_chk
  import regmap_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             busy_o,
  input logic             lk_cls_i,
  input logic [REG_W-1:0] lk_reg_i,
  input logic [REG_W-1:0] lk_start_o,
  input logic [EW_W-1:0]  lk_ew_o,
  input logic             lk_vec_o,
  input logic             lk_simd_o
);
  localparam int unsigned REBUILD = N_ENT + 1;
  logic [IDX_W+1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_cnt <= '0;
    else if (cfg_we_i) busy_cnt <= '0;
    else if (busy_o)   busy_cnt <= busy_cnt + 1'b1;
  end

  a_r2_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> busy_o);

  a_r10_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt == (IDX_W+2)'(REBUILD));

  a_r3_default_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (lk_start_o == lk_reg_i && lk_ew_o == '0 && !lk_vec_o && !lk_simd_o));

  a_r5_scalar_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_vec_o |-> lk_start_o == lk_reg_i);

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cfg_we_i) |=>
      (!($stable(lk_cls_i) && $stable(lk_reg_i)) ||
       ($stable(lk_start_o) && $stable(lk_ew_o) && $stable(lk_vec_o) && $stable(lk_simd_o))));
endmodule

bind regmap_builder regmap_builder_chk u_chk (.*);

// File: tb/regmap_builder_test.sv
module regmap_builder_test;
  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [3:0] idx = 0;
  logic [15:0] data = 0;
  logic busy, cls = 0, vec, simd, bank;
  logic [4:0] rg = 0, start;
  logic [1:0] ew;
  int errors = 0, checks = 0;
  logic [15:0] model [16];

  always #5 clk = ~clk;

  regmap_builder uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(idx), .cfg_data_i(data),
    .busy_o(busy), .lk_cls_i(cls), .lk_reg_i(rg), .lk_start_o(start), .lk_ew_o(ew),
    .lk_vec_o(vec), .lk_simd_o(simd), .lk_bank_o(bank));

  function automatic logic [15:0] mk(logic c, logic [4:0] k, logic [4:0] t,
                                     logic [1:0] w, logic v, logic s, logic b);
    return {c, k, t, w, v, s, b};
  endfunction

  // expected {start, ew, vec, simd, bank}
  function automatic logic [9:0] expect_row(logic c, logic [4:0] r);
    logic [4:0] t = 0; logic [1:0] w = 0; logic v = 0, s = 0;
    for (int i = 0; i < 16; i++)
      if (!model[i][0] && model[i][15] == c && model[i][14:10] == r) begin
        t = model[i][9:5]; w = model[i][4:3]; v = model[i][2]; s = model[i][1];
      end
    return {v ? t : r, w, v, s, 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(string req, logic c, logic [4:0] r, bit dflt);
    cls = c; rg = r; #1;
    check(req, {start, ew, vec, simd, bank}, dflt ? {r, 5'b0} : expect_row(c, r));
  endtask

  task automatic wr(logic [3:0] i, logic [15:0] d);
    @(negedge clk); we = 1; idx = i; data = d; model[i] = d;
    @(negedge clk); we = 0;
  endtask

  task automatic wait_idle(string req, bit chk_len);
    int n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    if (chk_len) check(req, n, 17);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    look("R1", 0, 5'd7, 1);
    look("R1", 1, 5'd31, 1);

    // R2 busy length, R3 defaults while busy, R4 vector remap
    wr(4'd0, mk(0, 5'd3, 5'd20, 2'd2, 1, 1, 0));
    check("R2 busy", busy, 1);
    look("R3", 0, 5'd3, 1);
    wait_idle("R2 len", 1);
    look("R4", 0, 5'd3, 0);
    check("R4 start", start, 20);

    // R5 scalar entry keeps register number
    wr(4'd1, mk(0, 5'd9, 5'd1, 2'd1, 0, 1, 0));
    wait_idle("R2 len", 1);
    look("R5", 0, 5'd9, 0);
    check("R5 start", start, 9);

    // R6 class separation
    look("R6", 1, 5'd3, 0);
    check("R6 vec", vec, 0);

    // R7 later slot wins
    wr(4'd5, mk(0, 5'd3, 5'd11, 2'd3, 1, 0, 0));
    wait_idle("R7", 0);
    look("R7", 0, 5'd3, 0);
    check("R7 start", start, 11);

    // R8 rekey clears old row
    wr(4'd5, mk(1, 5'd3, 5'd12, 2'd0, 1, 0, 0));
    wr(4'd0, mk(0, 5'd4, 5'd13, 2'd0, 1, 0, 0));
    wait_idle("R8", 0);
    look("R8", 0, 5'd3, 1);
    look("R8", 1, 5'd3, 0);

    // R9 reserved bank ignored
    wr(4'd6, mk(0, 5'd15, 5'd30, 2'd2, 1, 1, 1));
    wait_idle("R9", 0);
    look("R9", 0, 5'd15, 1);
    check("R9 bank", bank, 0);

    // R10 restart during rebuild
    wr(4'd7, mk(0, 5'd16, 5'd2, 2'd0, 1, 0, 0));
    repeat (5) @(negedge clk);
    wr(4'd8, mk(0, 5'd17, 5'd3, 2'd0, 1, 0, 0));
    wait_idle("R10 len", 1);
    look("R10", 0, 5'd16, 0);

    // random mix: colliding keys, then sweep and idle hold (R11)
    for (int k = 0; k < 40; k++) begin
      wr(4'($urandom), mk(1'($urandom), 5'($urandom_range(0, 5)), 5'($urandom),
                          2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0)));
      wait_idle("R2 len", 1);
      for (int r = 0; r < 6; r++) begin
        look("R4 rand", 0, 5'(r), 0);
        look("R6 rand", 1, 5'(r), 0);
      end
      @(negedge clk);
      look("R11", 1'($urandom), 5'($urandom_range(0, 7)), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule